// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block is the command interpreter of a byte-wide parallel NOR flash, modelled synchronously. Each bus write arrives as one cycle of `wr_valid_i` carrying an address and a data byte. The block follows the unlock-protected write sequences and recognises five commands: byte program, sector erase, chip erase, identification entry and identification exit. When a program or erase sequence completes, it emits a single-cycle start pulse. The target byte address and data, or the sector number, are latched alongside the pulse for the array controller.

A separate read-side selector tells the read path whether to return array data or an identification code for the current read address. An external operation timer drives `busy_i` while a program or erase is running. During that time every write is discarded. A sequence that breaks off partway is dropped, and the block falls back to plain read behaviour.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset `id_mode_o` is 0, all start pulses are 0, and no sequence is in progress: a lone write of any single cycle of a longer sequence starts nothing.
- R2: Command cycles compare only address bits 14..0; higher bits are don't-care. Step one is 0x5555 with data 0xAA, step two is 0x2AAA with data 0x55, and step three must be at 0x5555.
- R3: Step-three data 0xA0 makes the next accepted write the program target. `prog_start_o` is high for exactly the cycle after that write's clock edge, with `prog_addr_o`/`prog_data_o` equal to that write's address and data, even when the target write looks like a command cycle.
- R4: Step-three data 0x80 requires steps four and five to be 0x5555/0xAA and 0x2AAA/0x55. A sixth write with data 0x30 at any address pulses `sect_erase_o`, with `sector_o` equal to address bits ADDR_W-1..12.
- R5: A sixth erase-path write with data 0x10 at address 0x5555 pulses `chip_erase_o`; data 0x10 at any other address starts nothing.
- R6: Step-three data 0x90 sets `id_mode_o` from the next cycle on. While it is set, `rd_sel_id_o` is 1 exactly when `rd_addr_i` bits ADDR_W-1..1 are all 0. `rd_id_data_o` is then 0xBF for bit 0 = 0 and DEV_CODE for bit 0 = 1; otherwise it is 0x00.
- R7: Identification mode clears after either of two writes: a write of 0xF0 to any address while no sequence is in progress, or step-three data 0xF0 at 0x5555.
- R8: A write that does not match the expected step returns the sequence to its start. That write is not taken as a new step one, and it starts nothing.
- R9: While `busy_i` is 1, writes have no effect. The sequence position, `id_mode_o` and all start outputs are left as they were, and identification exit is ignored too.
- R10: At most one start pulse is high in any cycle, and none is high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | One bus write this cycle |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| busy_i | input | 1 | Program/erase in progress (from operation timer) |
| rd_addr_i | input | ADDR_W | Current read address |
| prog_start_o | output | 1 | Byte program start pulse |
| prog_addr_o | output | ADDR_W | Latched program address |
| prog_data_o | output | 8 | Latched program data |
| sect_erase_o | output | 1 | Sector erase start pulse |
| sector_o | output | ADDR_W-12 | Latched sector number |
| chip_erase_o | output | 1 | Chip erase start pulse |
| id_mode_o | output | 1 | Identification mode active |
| rd_sel_id_o | output | 1 | Read path returns identification code |
| rd_id_data_o | output | 8 | Identification code for rd_addr_i |

## Verification
The assertions assume that `wr_valid_i` marks each bus write in one clock cycle, and that address, data and `busy_i` are settled at the sampling edge. They also assume that `busy_i` only masks writes and is never needed to end a pulse. The stimulus changes every input one time unit after the rising edge and holds it for a full cycle. It drives `busy_i` on its own, both during partial sequences and on exit commands, so the lockout is exercised independently of any real timer. Pseudo-random writes drawn mostly from the magic address/data pairs keep the sequences within legal bus cycles while reaching abort and restart corners.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam int CMD_AW   = 15;
  localparam int SECT_LSB = 12;

  localparam logic [CMD_AW-1:0] ADDR_KEY_A = 15'h5555;
  localparam logic [CMD_AW-1:0] ADDR_KEY_B = 15'h2AAA;

  localparam logic [7:0] KEY_A     = 8'hAA;
  localparam logic [7:0] KEY_B     = 8'h55;
  localparam logic [7:0] OP_PROG   = 8'hA0;
  localparam logic [7:0] OP_ERASE  = 8'h80;
  localparam logic [7:0] OP_ID     = 8'h90;
  localparam logic [7:0] OP_EXIT   = 8'hF0;
  localparam logic [7:0] OP_SECT   = 8'h30;
  localparam logic [7:0] OP_CHIP   = 8'h10;
  localparam logic [7:0] MFR_CODE  = 8'hBF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_PROG,
    ST_ER3,
    ST_ER4,
    ST_ER5
  } step_e;

  typedef struct packed {
    logic key_a;
    logic key_b;
    logic cmd_addr;
    logic prog;
    logic erase;
    logic id_in;
    logic id_out;
    logic sect;
    logic chip;
  } match_t;
endpackage

// File: rtl/nor_cmd_match.sv
module nor_cmd_match
  import nor_cmd_pkg::*;
(
  input  logic [CMD_AW-1:0] addr_i,
  input  logic [7:0]        data_i,
  output match_t            match_o
);
  logic at_a, at_b;

  assign at_a = (addr_i == ADDR_KEY_A);
  assign at_b = (addr_i == ADDR_KEY_B);

  always_comb begin
    match_o          = '0;
    match_o.key_a    = at_a && (data_i == KEY_A);
    match_o.key_b    = at_b && (data_i == KEY_B);
    match_o.cmd_addr = at_a;
    match_o.prog     = (data_i == OP_PROG);
    match_o.erase    = (data_i == OP_ERASE);
    match_o.id_in    = (data_i == OP_ID);
    match_o.id_out   = (data_i == OP_EXIT);
    match_o.sect     = (data_i == OP_SECT);
    match_o.chip     = at_a && (data_i == OP_CHIP);
  end
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  localparam int SECT_W = ADDR_W - SECT_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  match_t            match_i,
  output logic              prog_start_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [7:0]        prog_data_o,
  output logic              sect_erase_o,
  output logic [SECT_W-1:0] sector_o,
  output logic              chip_erase_o,
  output logic              id_mode_o
);
  step_e             step_q, step_d;
  logic              id_q, id_d;
  logic              prog_d, sect_d, chip_d;
  logic [ADDR_W-1:0] paddr_d;
  logic [7:0]        pdata_d;
  logic [SECT_W-1:0] sector_d;

  always_comb begin
    step_d   = step_q;
    id_d     = id_q;
    prog_d   = 1'b0;
    sect_d   = 1'b0;
    chip_d   = 1'b0;
    paddr_d  = prog_addr_o;
    pdata_d  = prog_data_o;
    sector_d = sector_o;
    if (wr_en_i) begin
      case (step_q)
        ST_IDLE: begin
          if (match_i.key_a)       step_d = ST_KEY1;
          else if (match_i.id_out) id_d   = 1'b0;
        end
        ST_KEY1: step_d = match_i.key_b ? ST_KEY2 : ST_IDLE;
        ST_KEY2: begin
          step_d = ST_IDLE;
          if (match_i.cmd_addr) begin
            if (match_i.prog)        step_d = ST_PROG;
            else if (match_i.erase)  step_d = ST_ER3;
            else if (match_i.id_in)  id_d   = 1'b1;
            else if (match_i.id_out) id_d   = 1'b0;
          end
        end
        ST_PROG: begin
          step_d  = ST_IDLE;
          prog_d  = 1'b1;
          paddr_d = addr_i;
          pdata_d = data_i;
        end
        ST_ER3: step_d = match_i.key_a ? ST_ER4 : ST_IDLE;
        ST_ER4: step_d = match_i.key_b ? ST_ER5 : ST_IDLE;
        ST_ER5: begin
          step_d = ST_IDLE;
          if (match_i.sect) begin
            sect_d   = 1'b1;
            sector_d = addr_i[ADDR_W-1:SECT_LSB];
          end else if (match_i.chip) begin
            chip_d = 1'b1;
          end
        end
        default: step_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q       <= ST_IDLE;
      id_q         <= 1'b0;
      prog_start_o <= 1'b0;
      sect_erase_o <= 1'b0;
      chip_erase_o <= 1'b0;
      prog_addr_o  <= '0;
      prog_data_o  <= '0;
      sector_o     <= '0;
    end else begin
      step_q       <= step_d;
      id_q         <= id_d;
      prog_start_o <= prog_d;
      sect_erase_o <= sect_d;
      chip_erase_o <= chip_d;
      prog_addr_o  <= paddr_d;
      prog_data_o  <= pdata_d;
      sector_o     <= sector_d;
    end
  end

  assign id_mode_o = id_q;

  // R10
  one_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_start_o, sect_erase_o, chip_erase_o}));

  // R10
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_start_o || sect_erase_o || chip_erase_o) |=>
      !(prog_start_o || sect_erase_o || chip_erase_o));

  // R3
  prog_after_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> $past(step_q) == ST_PROG);
endmodule

// File: rtl/nor_id_read.sv
module nor_id_read
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter logic [7:0] DEV_CODE = 8'hA7
) (
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_sel_id_o,
  output logic [7:0]        rd_id_data_o
);
  logic upper_zero;

  assign upper_zero   = (rd_addr_i[ADDR_W-1:1] == '0);
  assign rd_sel_id_o  = id_mode_i && upper_zero;
  assign rd_id_data_o = !rd_sel_id_o ? 8'h00 : (rd_addr_i[0] ? DEV_CODE : MFR_CODE);
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter logic [7:0] DEV_CODE = 8'hA7,
  localparam int SECT_W = ADDR_W - SECT_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              prog_start_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [7:0]        prog_data_o,
  output logic              sect_erase_o,
  output logic [SECT_W-1:0] sector_o,
  output logic              chip_erase_o,
  output logic              id_mode_o,
  output logic              rd_sel_id_o,
  output logic [7:0]        rd_id_data_o
);
  match_t match;
  logic   wr_en;

  assign wr_en = wr_valid_i && !busy_i;

  nor_cmd_match u_match (
    .addr_i  (wr_addr_i[CMD_AW-1:0]),
    .data_i  (wr_data_i),
    .match_o (match)
  );

  nor_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en),
    .addr_i       (wr_addr_i),
    .data_i       (wr_data_i),
    .match_i      (match),
    .prog_start_o (prog_start_o),
    .prog_addr_o  (prog_addr_o),
    .prog_data_o  (prog_data_o),
    .sect_erase_o (sect_erase_o),
    .sector_o     (sector_o),
    .chip_erase_o (chip_erase_o),
    .id_mode_o    (id_mode_o)
  );

  nor_id_read #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_id (
    .id_mode_i    (id_mode_o),
    .rd_addr_i    (rd_addr_i),
    .rd_sel_id_o  (rd_sel_id_o),
    .rd_id_data_o (rd_id_data_o)
  );

  // R9
  busy_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(prog_start_o || sect_erase_o || chip_erase_o) && $stable(id_mode_o));

  // R3
  prog_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> $past(wr_valid_i) && prog_data_o == $past(wr_data_i)
                     && prog_addr_o == $past(wr_addr_i));

  // R4
  sector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sect_erase_o |-> $past(wr_data_i) == OP_SECT
                     && sector_o == $past(wr_addr_i[ADDR_W-1:SECT_LSB]));

  // R5
  chip_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_erase_o |-> $past(wr_addr_i[CMD_AW-1:0]) == ADDR_KEY_A && $past(wr_data_i) == OP_CHIP);

  // R6
  id_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(id_mode_o) |-> $past(wr_valid_i && !busy_i) && $past(wr_data_i) == OP_ID);

  // R7
  id_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(id_mode_o) |-> $past(wr_valid_i && !busy_i) && $past(wr_data_i) == OP_EXIT);
endmodule

// File: tb/tb_nor_cmd_decoder.sv
module tb_nor_cmd_decoder;
  localparam int AW = 19;
  localparam logic [7:0] DEV = 8'hA7;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_valid_i = 1'b0, busy_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic prog_start_o, sect_erase_o, chip_erase_o, id_mode_o, rd_sel_id_o;
  logic [AW-1:0] prog_addr_o;
  logic [7:0] prog_data_o, rd_id_data_o;
  logic [AW-13:0] sector_o;

  nor_cmd_decoder #(.ADDR_W(AW), .DEV_CODE(DEV)) dut (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: step counter 0..6, id flag, pulse flags
  int m_step = 0;
  bit m_id = 0, m_prog = 0, m_sect = 0, m_chip = 0;
  longint m_paddr = 0, m_pdata = 0, m_sector = 0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_step = 0; m_id = 0; m_prog = 0; m_sect = 0; m_chip = 0;
      m_paddr = 0; m_pdata = 0; m_sector = 0;
    end else begin
      int a15, d;
      m_prog = 0; m_sect = 0; m_chip = 0;
      a15 = int'(wr_addr_i) & 32'h7FFF;
      d = int'(wr_data_i);
      if (wr_valid_i && !busy_i) begin
        if (m_step == 0) begin
          if (a15 == 'h5555 && d == 'hAA) m_step = 1;
          else if (d == 'hF0) m_id = 0;
        end else if (m_step == 1 || m_step == 5) begin
          m_step = (a15 == 'h2AAA && d == 'h55) ? m_step + 1 : 0;
        end else if (m_step == 2) begin
          m_step = 0;
          if (a15 == 'h5555) begin
            if (d == 'hA0) m_step = 3;
            else if (d == 'h80) m_step = 4;
            else if (d == 'h90) m_id = 1;
            else if (d == 'hF0) m_id = 0;
          end
        end else if (m_step == 3) begin
          m_prog = 1; m_paddr = longint'(wr_addr_i); m_pdata = d; m_step = 0;
        end else if (m_step == 4) begin
          m_step = (a15 == 'h5555 && d == 'hAA) ? 5 : 0;
        end else begin
          if (d == 'h30) begin m_sect = 1; m_sector = longint'(wr_addr_i) >> 12; end
          else if (d == 'h10 && a15 == 'h5555) m_chip = 1;
          m_step = 0;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni) begin
      bit esel;
      longint edat;
      esel = m_id && ((rd_addr_i >> 1) == 0);
      edat = !esel ? 0 : (rd_addr_i[0] ? longint'(DEV) : 'hBF);
      chk(prog_start_o == m_prog, "R3 prog_start", prog_start_o, m_prog);
      if (m_prog) chk(prog_addr_o == m_paddr[AW-1:0] && prog_data_o == m_pdata[7:0],
                      "R3 prog target", {prog_addr_o, prog_data_o}, {m_paddr[AW-1:0], m_pdata[7:0]});
      chk(sect_erase_o == m_sect, "R4 sect_erase", sect_erase_o, m_sect);
      if (m_sect) chk(sector_o == m_sector[AW-13:0], "R4 sector", sector_o, m_sector);
      chk(chip_erase_o == m_chip, "R5 chip_erase", chip_erase_o, m_chip);
      chk(id_mode_o == m_id, "R6 R7 id_mode", id_mode_o, m_id);
      chk(rd_sel_id_o == esel, "R6 rd_sel", rd_sel_id_o, esel);
      chk(rd_id_data_o == edat[7:0], "R6 rd_data", rd_id_data_o, edat);
      chk($countones({prog_start_o, sect_erase_o, chip_erase_o}) <= 1, "R10 one pulse",
          $countones({prog_start_o, sect_erase_o, chip_erase_o}), 1);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_valid_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic unlock(input logic [AW-1:0] hi);
    wr(hi | 19'h05555, 8'hAA);
    wr(hi | 19'h02AAA, 8'h55);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input bit sel);
    rd_addr_i = a; #1;
    chk(rd_sel_id_o == sel && rd_id_data_o == exp, "R6 id read", {rd_sel_id_o, rd_id_data_o}, {sel, exp});
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    #1;
    chk(id_mode_o == 0 && !prog_start_o && !sect_erase_o && !chip_erase_o, "R1 reset state",
        {id_mode_o, prog_start_o, sect_erase_o, chip_erase_o}, 0);
    // lone program-target write after reset must start nothing
    wr(19'h01234, 8'h55);
    chk(!prog_start_o, "R1 no sequence after reset", prog_start_o, 0);
    idle(1);

    // R2: upper address bits set on command cycles
    unlock(19'h70000);
    wr(19'h45555, 8'hA0);
    wr(19'h12345, 8'h3C);
    chk(prog_start_o && prog_addr_o == 19'h12345 && prog_data_o == 8'h3C, "R2 R3 program",
        {prog_start_o, prog_data_o}, {1'b1, 8'h3C});
    idle(1);
    chk(!prog_start_o, "R10 pulse width", prog_start_o, 0);

    // R3: target write that looks like step one
    unlock(0); wr(19'h05555, 8'hA0); wr(19'h05555, 8'hAA);
    chk(prog_start_o && prog_data_o == 8'hAA, "R3 target looks like key", prog_data_o, 8'hAA);

    // R4: sector erase
    unlock(0); wr(19'h05555, 8'h80); unlock(0); wr(19'h4A123, 8'h30);
    chk(sect_erase_o && sector_o == 7'h4A, "R4 sector erase", sector_o, 7'h4A);
    // R5: chip erase, then wrong address for 0x10
    unlock(0); wr(19'h05555, 8'h80); unlock(19'h08000); wr(19'h05555, 8'h10);
    chk(chip_erase_o, "R5 chip erase", chip_erase_o, 1);
    unlock(0); wr(19'h05555, 8'h80); unlock(0); wr(19'h05554, 8'h10);
    chk(!chip_erase_o && !sect_erase_o, "R5 chip erase wrong addr", chip_erase_o, 0);

    // R6: ID mode reads
    unlock(0); wr(19'h05555, 8'h90);
    chk(id_mode_o, "R6 id entry", id_mode_o, 1);
    rd(19'h00000, 8'hBF, 1);
    rd(19'h00001, DEV, 1);
    rd(19'h00002, 8'h00, 0);
    rd(19'h40001, 8'h00, 0);
    // R7: single-write exit
    wr(19'h03333, 8'hF0);
    chk(!id_mode_o, "R7 single exit", id_mode_o, 0);
    rd(19'h00000, 8'h00, 0);
    // R7: three-cycle exit
    unlock(0); wr(19'h05555, 8'h90);
    unlock(0); wr(19'h05555, 8'hF0);
    chk(!id_mode_o, "R7 three-cycle exit", id_mode_o, 0);

    // R8: aborts
    wr(19'h05555, 8'hAA); wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
    wr(19'h05555, 8'hA0); wr(19'h00100, 8'h11);
    chk(!prog_start_o, "R8 repeated key not a restart", prog_start_o, 0);
    unlock(0); wr(19'h05555, 8'h77); wr(19'h00200, 8'h22);
    chk(!prog_start_o, "R8 bad opcode abort", prog_start_o, 0);
    unlock(0); wr(19'h05556, 8'hA0); wr(19'h00300, 8'h33);
    chk(!prog_start_o, "R8 bad step-three addr", prog_start_o, 0);
    unlock(0); wr(19'h05555, 8'h80); wr(19'h05555, 8'hAB);
    unlock(0); wr(19'h01000, 8'h30);
    chk(!sect_erase_o, "R8 erase path abort", sect_erase_o, 0);

    // R9: busy lockout
    unlock(0); wr(19'h05555, 8'h90);
    busy_i = 1'b1; wr(19'h00000, 8'hF0);
    chk(id_mode_o, "R9 exit ignored while busy", id_mode_o, 1);
    busy_i = 1'b0;
    wr(19'h05555, 8'hAA);
    busy_i = 1'b1; wr(19'h00000, 8'h00); busy_i = 1'b0;
    wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
    busy_i = 1'b1; wr(19'h00400, 8'h44);
    chk(!prog_start_o, "R9 target ignored while busy", prog_start_o, 0);
    busy_i = 1'b0; wr(19'h00404, 8'h45);
    chk(prog_start_o && prog_addr_o == 19'h00404, "R9 sequence held across busy", prog_addr_o, 19'h00404);

    // R1: mid-run reset clears ID mode and partial sequence
    unlock(0);
    rst_ni = 1'b0; idle(2); rst_ni = 1'b1; #1;
    chk(!id_mode_o, "R1 reset clears id", id_mode_o, 0);
    wr(19'h05555, 8'hA0); wr(19'h00500, 8'h55);
    chk(!prog_start_o, "R1 reset clears sequence", prog_start_o, 0);

    // pseudo-random writes biased to command pairs
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [AW-1:0] hi;
      k = int'($urandom % 10);
      hi = {3'($urandom), 16'h0};
      busy_i = ($urandom % 8) == 0;
      case (k)
        0, 1: wr(hi | 19'h05555, 8'hAA);
        2, 3: wr(hi | 19'h02AAA, 8'h55);
        4: wr(hi | 19'h05555, 8'hA0);
        5: wr(hi | 19'h05555, 8'h80);
        6: wr(hi | 19'h05555, ($urandom % 2) ? 8'h90 : 8'hF0);
        7: wr(19'($urandom), ($urandom % 2) ? 8'h30 : 8'h10);
        8: begin rd_addr_i = 19'($urandom % 4); idle(1); end
        default: wr(19'($urandom), 8'($urandom));
      endcase
    end
    busy_i = 1'b0;
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule